// File: doc/BRIEF.md
# Credit-Gated Link Layer with CRC Retry

This block is the link layer of a point-to-point connection: a sending endpoint and a receiving endpoint joined by a 20-lane data path. The sender accepts 72-bit payloads on a valid/ready stream. It protects each payload with an 8-bit CRC and sends the 80-bit unit over the lanes in four beats. The receiver rebuilds each unit and checks the CRC. Good payloads go into a receive buffer, which drains through a second valid/ready stream.

Flow control works on credits. The sender starts with a fixed number of credits and uses one for every payload it accepts. The receiver gives one credit back each time its consumer takes a payload. The sender also keeps every sent payload in a replay buffer until the receiver acknowledges it. When a unit arrives corrupt, the receiver asks for a resend and ignores the units that follow until a replay-marked unit arrives. Delivery therefore stays in order, with no loss and no duplicates.

Back-pressure rules:
- The producer holds `in_valid` and `in_data` steady until a cycle in which `in_ready` is high. The payload is taken at that clock edge.
- The consumer may hold `out_ready` low for as long as it likes. `out_valid` and `out_data` stay unchanged while it does.
- The lane pair is left open at the ports so that the path between the endpoints can be modelled or disturbed. The acknowledge, retry and credit signals stay inside the block.
- The `CREDITS` parameter must not exceed `RX_DEPTH`.

Top module: `credit_link`

## Requirements
- R1: The sender starts with CREDITS (default 8) credits. Each accepted payload uses one. `in_ready` is low whenever the credit count is zero.
- R2: Each pop on the output stream (`out_valid && out_ready`) returns one credit. With no other traffic, `in_ready` is high again a few cycles after the pop.
- R3: A unit is `{crc[7:0], payload[71:0]}`, 80 bits. It is sent on `txl_data` over 4 consecutive cycles with `txl_vld` high, in the order bits [19:0], [39:20], [59:40], [79:60].
- R4: The CRC uses polynomial 0x07 (x^8+x^2+x+1) with initial value 0x00 and no final inversion. It processes the payload from bit 71 down to bit 0.
- R5: Payloads whose CRC matches leave on `out_data` in the order they were accepted, each exactly once.
- R6: When a received CRC does not match, the receiver drops the unit and requests a resend. The sender finishes the unit it is sending, then resends from the oldest unacknowledged payload. `txl_rply` is high on every beat of that first resent unit.
- R7: After a mismatch, the receiver discards every unit with the replay flag low until a unit with the flag high arrives. Nothing is lost or duplicated, even when the resent unit is corrupt as well.
- R8: While `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: After reset, `in_ready` is high and `out_valid`, `txl_vld` and `txl_rply` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Payload can be taken (credit and replay space available) |
| in_data | input | 72 | Payload to send |
| out_valid | output | 1 | Delivered payload available |
| out_ready | input | 1 | Consumer takes the payload |
| out_data | output | 72 | Delivered payload |
| txl_vld | output | 1 | Sending lanes carry a beat |
| txl_rply | output | 1 | Beat belongs to the first resent unit |
| txl_data | output | 20 | Sending lane beat |
| rxl_vld | input | 1 | Receiving lanes carry a beat |
| rxl_rply | input | 1 | Replay flag of the received beat |
| rxl_data | input | 20 | Receiving lane beat |

## Verification
A credit count that drifts shows at the ports in one of two ways. Either `in_ready` stays low while the receive buffer is empty, or `in_ready` stays high after CREDITS payloads have gone unpopped; both are visible within a few cycles of the pops. A replay pointer or discard flag that goes wrong shows as a missing, repeated or reordered payload on `out_data`. This appears within one or two unit times, about 4 to 10 cycles, after a corrupted unit. A faulty CRC or a faulty beat order shows on the very first unit, either in the captured lane beats or as a retry when the unit is clean.

// File: rtl/clink_pkg.sv
package clink_pkg;
  localparam int PAY_W  = 72;
  localparam int CRC_W  = 8;
  localparam int UNIT_W = PAY_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  // Bit-serial CRC, payload MSB first, zero seed, no final inversion
  function automatic logic [CRC_W-1:0] crc_calc(input logic [PAY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/clink_tx.sv
module clink_tx
  import clink_pkg::*;
#(
  parameter int LANES    = 20,
  parameter int RB_DEPTH = 8,
  parameter int CREDITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_data,
  input  logic             ack_i,
  input  logic             retry_i,
  input  logic             credit_i,
  output logic             lane_vld,
  output logic             lane_rply,
  output logic [LANES-1:0] lane_data
);
  localparam int BEATS = UNIT_W / LANES;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int PW    = $clog2(RB_DEPTH) + 1;
  localparam int AW    = PW - 1;
  localparam int CW    = $clog2(CREDITS + 1);

  logic [PAY_W-1:0]  mem [RB_DEPTH];
  logic [PW-1:0]     wr, rd, snd, sel;
  logic [CW-1:0]     cred;
  logic              busy, rew_pend, rply_q, rew_eff, can_start, last, slot_free, full, in_fire;
  logic [BW-1:0]     bcnt;
  logic [UNIT_W-1:0] shreg;
  logic [PAY_W-1:0]  nxt_pay;

  assign full      = (wr - rd) == PW'(RB_DEPTH);
  assign in_ready  = (cred != '0) && !full;
  assign in_fire   = in_valid && in_ready;
  assign rew_eff   = rew_pend || retry_i;
  assign sel       = rew_eff ? rd : snd;
  assign can_start = sel != wr;
  assign last      = busy && (bcnt == BW'(BEATS - 1));
  assign slot_free = !busy || last;
  assign nxt_pay   = mem[sel[AW-1:0]];

  assign lane_vld  = busy;
  assign lane_rply = rply_q;
  assign lane_data = shreg[LANES-1:0];

  always_ff @(posedge clk) begin
    if (in_fire) mem[wr[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr       <= '0;
      rd       <= '0;
      snd      <= '0;
      cred     <= CW'(CREDITS);
      busy     <= 1'b0;
      rew_pend <= 1'b0;
      rply_q   <= 1'b0;
      bcnt     <= '0;
      shreg    <= '0;
    end else begin
      if (in_fire) wr <= wr + PW'(1);
      if (ack_i)   rd <= rd + PW'(1);
      if (in_fire && !credit_i)      cred <= cred - CW'(1);
      else if (!in_fire && credit_i) cred <= cred + CW'(1);
      if (slot_free) begin
        if (can_start) begin
          shreg    <= {crc_calc(nxt_pay), nxt_pay};
          busy     <= 1'b1;
          bcnt     <= '0;
          rply_q   <= rew_eff;
          snd      <= sel + PW'(1);
          rew_pend <= 1'b0;
        end else begin
          busy   <= 1'b0;
          rply_q <= 1'b0;
          if (retry_i) rew_pend <= 1'b1;
        end
      end else begin
        bcnt  <= bcnt + BW'(1);
        shreg <= shreg >> LANES;
        if (retry_i) rew_pend <= 1'b1;
      end
    end
  end

  // R1: an accept with no returning credit lowers the count by exactly one
  p_credit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !credit_i) |=> (cred == $past(cred) - CW'(1)));

  // R1: the count never rises above its starting value
  p_credit_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cred <= CW'(CREDITS));

  // R6: the replay buffer never holds more than its depth
  p_rb_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr - rd) <= PW'(RB_DEPTH));
endmodule

// File: rtl/clink_rx.sv
module clink_rx
  import clink_pkg::*;
#(
  parameter int LANES    = 20,
  parameter int RX_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lane_vld,
  input  logic             lane_rply,
  input  logic [LANES-1:0] lane_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_data,
  output logic             ack_o,
  output logic             retry_o,
  output logic             credit_o
);
  localparam int BEATS = UNIT_W / LANES;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int AS_W  = UNIT_W - LANES;
  localparam int QW    = $clog2(RX_DEPTH);
  localparam int NW    = $clog2(RX_DEPTH + 1);

  logic [AS_W-1:0]   asm_q;
  logic [BW-1:0]     bcnt;
  logic              discard, done, keep, good, push, pop;
  logic [UNIT_W-1:0] unit_w;
  logic [PAY_W-1:0]  fifo [RX_DEPTH];
  logic [QW-1:0]     wp, rp;
  logic [NW-1:0]     cnt;

  assign unit_w   = {lane_data, asm_q};
  assign good     = crc_calc(unit_w[PAY_W-1:0]) == unit_w[UNIT_W-1:PAY_W];
  assign done     = lane_vld && (bcnt == BW'(BEATS - 1));
  assign keep     = !discard || lane_rply;
  assign push     = done && keep && good;
  assign out_valid = cnt != '0;
  assign out_data  = fifo[rp];
  assign pop      = out_valid && out_ready;
  assign credit_o = pop;

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= unit_w[PAY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q   <= '0;
      bcnt    <= '0;
      discard <= 1'b0;
      ack_o   <= 1'b0;
      retry_o <= 1'b0;
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
    end else begin
      ack_o   <= 1'b0;
      retry_o <= 1'b0;
      if (lane_vld) begin
        asm_q <= {lane_data, asm_q[AS_W-1:LANES]};
        bcnt  <= done ? '0 : bcnt + BW'(1);
      end
      if (done && keep) begin
        if (good) begin
          ack_o   <= 1'b1;
          discard <= 1'b0;
        end else begin
          retry_o <= 1'b1;
          discard <= 1'b1;
        end
      end
      if (push) wp <= wp + QW'(1);
      if (pop)  rp <= rp + QW'(1);
      if (push && !pop)      cnt <= cnt + NW'(1);
      else if (!push && pop) cnt <= cnt - NW'(1);
    end
  end

  // R2: credits keep the receive buffer from overflowing
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt != NW'(RX_DEPTH)) || pop);

  // R8: a stalled output holds its payload
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/credit_link.sv
module credit_link
  import clink_pkg::*;
#(
  parameter int LANES    = 20,
  parameter int RB_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int CREDITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_data,
  output logic             txl_vld,
  output logic             txl_rply,
  output logic [LANES-1:0] txl_data,
  input  logic             rxl_vld,
  input  logic             rxl_rply,
  input  logic [LANES-1:0] rxl_data
);
  logic ack, retry, credit;

  clink_tx #(.LANES(LANES), .RB_DEPTH(RB_DEPTH), .CREDITS(CREDITS)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ack_i(ack), .retry_i(retry), .credit_i(credit),
    .lane_vld(txl_vld), .lane_rply(txl_rply), .lane_data(txl_data)
  );

  clink_rx #(.LANES(LANES), .RX_DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .lane_vld(rxl_vld), .lane_rply(rxl_rply), .lane_data(rxl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ack_o(ack), .retry_o(retry), .credit_o(credit)
  );
endmodule

// File: tb/credit_link_bench.sv
`timescale 1ns/1ps
module credit_link_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [71:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [71:0] out_data;
  logic        txl_vld, txl_rply, rxl_vld, rxl_rply;
  logic [19:0] txl_data, rxl_data;

  int ntests = 0;
  int nfail  = 0;
  int bad_req = 0;
  int bad_done = 0;
  int bb = 0;
  int rply_seen = 0;
  logic [79:0] cap = '0;
  logic flip;
  bit finished = 0;

  always #10 clk = ~clk;

  credit_link u_credit_link (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .txl_vld(txl_vld), .txl_rply(txl_rply), .txl_data(txl_data),
    .rxl_vld(rxl_vld), .rxl_rply(rxl_rply), .rxl_data(rxl_data)
  );

  // Loopback channel: flips bit 0 of the first beat of the next armed unit
  assign flip     = (bad_req > bad_done) && txl_vld && (bb == 0);
  assign rxl_vld  = txl_vld;
  assign rxl_rply = txl_rply;
  assign rxl_data = txl_data ^ (flip ? 20'h00001 : 20'h00000);

  always @(posedge clk) begin
    if (!rst_n) begin
      bb <= 0;
      bad_done <= 0;
      rply_seen <= 0;
    end else if (txl_vld) begin
      if (bb == 0 && bad_req > bad_done) bad_done <= bad_done + 1;
      if (bb == 0 && txl_rply) rply_seen <= rply_seen + 1;
      bb  <= (bb == 3) ? 0 : bb + 1;
      cap <= {txl_data, cap[79:20]};
    end
  end

  function automatic logic [7:0] ref_crc(input logic [71:0] d);
    logic [79:0] r;
    r = {d, 8'h00};
    for (int i = 79; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [71:0] d);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [71:0] d, input string req);
    int t;
    t = 0;
    while (!out_valid && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(out_valid, req, {79'b0, out_valid}, 80'h1);
    chk(out_data == d, req, {8'h0, out_data}, {8'h0, d});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R9 in_ready", {79'b0, in_ready}, 80'h1);
    chk(out_valid == 1'b0, "R9 out_valid", {79'b0, out_valid}, 80'h0);
    chk(txl_vld == 1'b0, "R9 txl_vld", {79'b0, txl_vld}, 80'h0);
    chk(txl_rply == 1'b0, "R9 txl_rply", {79'b0, txl_rply}, 80'h0);
  endtask

  task automatic t_single(input logic [71:0] p);
    push(p);
    pop_expect(p, "R5 single");
    chk(cap == {ref_crc(p), p}, "R3 beat order", cap, {ref_crc(p), p});
    chk(cap[79:72] == ref_crc(p), "R4 crc", {72'h0, cap[79:72]}, {72'h0, ref_crc(p)});
  endtask

  task automatic t_credit();
    logic [71:0] base, snap;
    base = 72'hA5_0000_0000_0000_1000;
    for (int i = 0; i < 8; i++) push(base + 72'(i));
    repeat (60) @(negedge clk);
    chk(in_ready == 1'b0, "R1 credits spent", {79'b0, in_ready}, 80'h0);
    snap = out_data;
    repeat (5) @(negedge clk);
    chk(out_valid && out_data == snap, "R8 hold", {8'h0, out_data}, {8'h0, snap});
    chk(snap == base, "R8 head", {8'h0, snap}, {8'h0, base});
    pop_expect(base, "R5 credit head");
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R2 credit back", {79'b0, in_ready}, 80'h1);
    push(base + 72'd8);
    for (int i = 1; i < 9; i++) pop_expect(base + 72'(i), "R5 credit order");
  endtask

  task automatic t_retry(input int nbad, input int n);
    int r0;
    logic [71:0] base;
    base = 72'h3C_0000_0000_0000_0000 + 72'(nbad * 256);
    r0 = rply_seen;
    bad_req = bad_req + nbad;
    for (int i = 0; i < n; i++) push(base + 72'(i));
    for (int i = 0; i < n; i++) pop_expect(base + 72'(i), "R7 order after retry");
    repeat (40) @(negedge clk);
    chk(out_valid == 1'b0, "R7 no duplicate", {79'b0, out_valid}, 80'h0);
    chk(rply_seen > r0, "R6 replay flagged", 80'(rply_seen), 80'(r0 + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(72'h12_3456_789A_BCDE_F012);
    t_single(72'hFF_FFFF_FFFF_FFFF_FFFF);
    t_single(72'hAA_5555_AAAA_5555_AAAA);
    t_single(72'h80_0000_0000_0000_0001);
    t_credit();
    t_retry(1, 4);
    t_retry(2, 3);
    t_retry(1, 1);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      ntests++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule